// File: doc/BRIEF.md
# Page-Mode Emulation Access Controller

This block times external memory accesses when bursts are emulated as a series of page-mode accesses instead of being clocked out. It accepts one internal access request at a time. For each one it drives a fresh external address and waits a programmed number of cycles. It then raises a one-cycle completion pulse. The address strobe stays asserted across every access of a multi-access sequence. It drops only when the access flagged as last has completed, or when emulation is switched off between accesses.

The wait for each access is either the initial wait count or the shorter page wait count. The page wait applies only when the access is sequential to the one before it and stays inside the same page. Sequential means the previous address plus one word, where a word is the configured external data width. The page size is programmed as 4, 8, 16 or 32 words. An access in the same page that is not sequential, or a sequential access that crosses into the next page, pays the full initial wait. A controlling unit supplies the request stream, the last-access marker and the timing configuration. The burst clock, the data path and error detection live elsewhere.

Top module: `pme_ctrl`

## Requirements
- R1: After reset, strobe_o, ack_o and page_hit_o are 0 and ext_addr_o is 0. req_ready_o is 1 whenever en_i is 1.
- R2: While en_i is 0, req_ready_o is 0 and requests are not accepted: no ack_o follows and strobe_o stays 0. If en_i is 0 while no access is in flight, the sequence is closed: strobe_o falls on the next cycle and the following access uses initial timing.
- R3: The first access of a sequence uses the initial wait count W = init_wait_i. ack_o is high in the cycle after the (W+1)-th clock edge following the accepting edge, and page_hit_o reads 0 with it.
- R4: An access whose address is the previous accepted address plus one word, and which lies in the same page, uses W = page_wait_i with the same cycle rule as R3. page_hit_o reads 1 with its ack_o.
- R5: An access in the same page that is not previous address plus one word uses init_wait_i, and page_hit_o reads 0.
- R6: A sequential access whose page index (address shifted right by log2 of the page size in bytes) differs from the previous one uses init_wait_i.
- R7: The word size in bytes follows dsz_i: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes.
- R8: Page size in words follows psz_i: 0 is 4, 1 is 8, 2 is 16, 3 is 32. The page size in bytes is the word count times the word size.
- R9: ext_addr_o takes the accepted address on the cycle after acceptance and holds it until the next acceptance.
- R10: strobe_o rises on the cycle after acceptance. It stays high through all accesses of a sequence and through the idle gaps between them. It falls on the cycle after the ack_o of an access accepted with req_last_i = 1. The next access then uses initial timing.
- R11: ack_o is a single-cycle pulse. req_ready_o is 0 from the cycle after acceptance through the ack_o cycle and returns to 1 on the cycle after it, provided en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Page-mode emulation enable |
| psz_i | input | 2 | Page size code |
| dsz_i | input | 2 | External data width code |
| init_wait_i | input | WW | Initial access wait count |
| page_wait_i | input | WW | Page access wait count |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | AW | Byte address of the request |
| req_last_i | input | 1 | Request is the last of its sequence |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| ext_addr_o | output | AW | External address |
| strobe_o | output | 1 | Address strobe, held across the sequence |
| ack_o | output | 1 | Access complete pulse |
| page_hit_o | output | 1 | Current access used page timing |

## Verification
The assertions assume that the configuration inputs do not change while an access is in flight. They also assume that en_i changes only when no access is outstanding, because the completion and strobe properties are written for a stable wait count and a stable enable. The stimulus changes psz_i, dsz_i, both wait counts and en_i only at falling edges while req_ready_o or the idle state is observed. Each request is held valid until it is accepted, so the hit decision always sees a settled address.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int unsigned PAGE_BASE_LOG2 = 2;  // smallest page: 4 words

  function automatic logic [1:0] word_shift(input logic [1:0] dsz);
    return (dsz == 2'd3) ? 2'd2 : dsz;
  endfunction

  function automatic logic [3:0] page_shift(input logic [1:0] psz, input logic [1:0] dsz);
    return {2'b00, psz} + 4'(PAGE_BASE_LOG2) + {2'b00, word_shift(dsz)};
  endfunction
endpackage

// File: rtl/pme_hit_detect.sv
module pme_hit_detect #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] cur_addr_i,
  input  logic [AW-1:0] prev_addr_i,
  input  logic          prev_valid_i,
  input  logic [1:0]    psz_i,
  input  logic [1:0]    dsz_i,
  output logic          hit_o
);
  import pme_pkg::*;

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step;
  logic [AW-1:0] diff;
  logic [3:0]    sh;
  logic          seq;
  logic          same_page;

  always_comb begin
    step      = ONE << word_shift(dsz_i);
    sh        = page_shift(psz_i, dsz_i);
    diff      = cur_addr_i ^ prev_addr_i;
    seq       = (cur_addr_i == (prev_addr_i + step));
    same_page = ((diff >> sh) == '0);
    hit_o     = prev_valid_i && seq && same_page;
  end
endmodule

// File: rtl/pme_wait_timer.sv
module pme_wait_timer #(
  parameter int unsigned WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [WW-1:0] load_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [WW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;  // pulse one cycle after expiry
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pme_ctrl.sv
module pme_ctrl #(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    psz_i,
  input  logic [1:0]    dsz_i,
  input  logic [WW-1:0] init_wait_i,
  input  logic [WW-1:0] page_wait_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_last_i,
  output logic          req_ready_o,
  output logic [AW-1:0] ext_addr_o,
  output logic          strobe_o,
  output logic          ack_o,
  output logic          page_hit_o
);
  logic          busy;
  logic          done;
  logic          accept;
  logic          hit;
  logic          idle;
  logic [WW-1:0] wait_sel;
  logic [AW-1:0] addr_q;
  logic          prev_valid_q;
  logic          seq_active_q;
  logic          last_q;
  logic          hit_q;

  assign idle        = !busy && !done;
  assign req_ready_o = en_i && idle;
  assign accept      = req_valid_i && req_ready_o;
  assign wait_sel    = hit ? page_wait_i : init_wait_i;

  pme_hit_detect #(.AW(AW)) u_hit (
    .cur_addr_i  (req_addr_i),
    .prev_addr_i (addr_q),
    .prev_valid_i(prev_valid_q),
    .psz_i       (psz_i),
    .dsz_i       (dsz_i),
    .hit_o       (hit)
  );

  pme_wait_timer #(.WW(WW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .load_i (wait_sel),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      prev_valid_q <= 1'b0;
      seq_active_q <= 1'b0;
      last_q       <= 1'b0;
      hit_q        <= 1'b0;
    end else if (accept) begin
      addr_q       <= req_addr_i;
      prev_valid_q <= 1'b1;
      seq_active_q <= 1'b1;
      last_q       <= req_last_i;
      hit_q        <= hit;
    end else if ((done && last_q) || (!en_i && idle)) begin
      // sequence closed: release strobe, forget page history
      prev_valid_q <= 1'b0;
      seq_active_q <= 1'b0;
      last_q       <= 1'b0;
      hit_q        <= 1'b0;
    end
  end

  assign ext_addr_o = addr_q;
  assign strobe_o   = seq_active_q;
  assign ack_o      = done;
  assign page_hit_o = hit_q;
endmodule

// File: rtl/pme_ctrl_chk.sv
module pme_ctrl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] ext_addr_o,
  input logic          strobe_o,
  input logic          ack_o,
  input logic          page_hit_o
);
  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !strobe_o) |=> !strobe_o);

  p_hit_in_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_hit_o |-> strobe_o);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(ext_addr_o));

  p_accept_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (strobe_o && !req_ready_o));

  p_ack_in_seq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (strobe_o && !req_ready_o));

  p_ack_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

bind pme_ctrl pme_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .ext_addr_o (ext_addr_o),
  .strobe_o   (strobe_o),
  .ack_o      (ack_o),
  .page_hit_o (page_hit_o)
);

// File: tb/pme_ctrl_test.sv
`timescale 1ns/1ps
module pme_ctrl_test;
  localparam int unsigned AW = 32;
  localparam int unsigned WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    psz = 2'd0;
  logic [1:0]    dsz = 2'd2;
  logic [WW-1:0] iw = 4'd3;
  logic [WW-1:0] pw = 4'd1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_last = 1'b0;
  logic          req_ready;
  logic [AW-1:0] ext_addr;
  logic          strobe;
  logic          ack;
  logic          page_hit;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pme_ctrl #(.AW(AW), .WW(WW)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .psz_i      (psz),
    .dsz_i      (dsz),
    .init_wait_i(iw),
    .page_wait_i(pw),
    .req_valid_i(req_valid),
    .req_addr_i (req_addr),
    .req_last_i (req_last),
    .req_ready_o(req_ready),
    .ext_addr_o (ext_addr),
    .strobe_o   (strobe),
    .ack_o      (ack),
    .page_hit_o (page_hit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one access: hold request until accepted, measure cycles to ack
  task automatic do_access(input logic [AW-1:0] a, input logic last,
                           input logic exp_hit, input string tag);
    int k;
    int exp_k;
    req_valid = 1'b1;
    req_addr  = a;
    req_last  = last;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ext_addr == a, "R9 addr after accept", ext_addr, a);
    chk(strobe == 1'b1, "R10 strobe after accept", strobe, 1);
    chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
    k = 0;
    while (!ack && k < 64) begin
      @(negedge clk);
      k++;
    end
    exp_k = (exp_hit ? int'(pw) : int'(iw)) + 1;
    chk(k == exp_k, {tag, " wait cycles"}, k, exp_k);
    chk(page_hit == exp_hit, {tag, " page hit"}, page_hit, exp_hit);
    chk(ext_addr == a, "R9 addr held to ack", ext_addr, a);
    @(negedge clk);
    chk(ack == 1'b0, "R11 ack single cycle", ack, 0);
    chk(req_ready == 1'b1, "R11 ready after ack", req_ready, 1);
    chk(strobe == !last, "R10 strobe after ack", strobe, !last);
  endtask

  task automatic cfg(input logic [1:0] p, input logic [1:0] d,
                     input logic [WW-1:0] i, input logic [WW-1:0] g);
    psz = p; dsz = d; iw = i; pw = g;
  endtask

  task automatic t_reset();
    chk(strobe == 1'b0, "R1 strobe", strobe, 0);
    chk(ack == 1'b0, "R1 ack", ack, 0);
    chk(page_hit == 1'b0, "R1 page_hit", page_hit, 0);
    chk(ext_addr == '0, "R1 ext_addr", ext_addr, 0);
    chk(req_ready == 1'b0, "R1 ready with en low", req_ready, 0);
    en = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready with en high", req_ready, 1);
  endtask

  task automatic t_disabled();
    int acks = 0;
    int strobes = 0;
    en = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'h80;
    repeat (8) begin
      @(negedge clk);
      if (ack) acks++;
      if (strobe) strobes++;
    end
    chk(acks == 0, "R2 no ack when disabled", acks, 0);
    chk(strobes == 0, "R2 no strobe when disabled", strobes, 0);
    chk(req_ready == 1'b0, "R2 ready low when disabled", req_ready, 0);
    chk(ext_addr == '0, "R2 address untouched", ext_addr, 0);
    req_valid = 1'b0;
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_seq_word();
    cfg(2'd0, 2'd2, 4'd3, 4'd1);
    do_access(32'h100, 1'b0, 1'b0, "R3");
    do_access(32'h104, 1'b0, 1'b1, "R4");
    do_access(32'h108, 1'b0, 1'b1, "R4");
    do_access(32'h10C, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_nonseq();
    cfg(2'd0, 2'd2, 4'd5, 4'd2);
    do_access(32'h200, 1'b0, 1'b0, "R3");
    do_access(32'h208, 1'b0, 1'b0, "R5");
    do_access(32'h20C, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_cross();
    cfg(2'd0, 2'd2, 4'd4, 4'd1);
    do_access(32'h30C, 1'b0, 1'b0, "R3");
    do_access(32'h310, 1'b0, 1'b0, "R6");
    do_access(32'h314, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_byte();
    cfg(2'd1, 2'd0, 4'd3, 4'd0);  // 8-byte page
    do_access(32'h40, 1'b0, 1'b0, "R3");
    do_access(32'h41, 1'b0, 1'b1, "R7 byte step");
    do_access(32'h43, 1'b0, 1'b0, "R5");
    do_access(32'h44, 1'b0, 1'b1, "R7 byte step");
    do_access(32'h47, 1'b0, 1'b0, "R5");
    do_access(32'h48, 1'b1, 1'b0, "R8 8-byte page cross");
  endtask

  task automatic t_half();
    cfg(2'd3, 2'd1, 4'd3, 4'd1);  // 64-byte page
    do_access(32'h1E, 1'b0, 1'b0, "R3");
    do_access(32'h20, 1'b0, 1'b1, "R8 32-word page");
    do_access(32'h3E, 1'b0, 1'b0, "R5");
    do_access(32'h40, 1'b0, 1'b0, "R6");
    do_access(32'h42, 1'b0, 1'b1, "R7 half step");
    do_access(32'h46, 1'b1, 1'b0, "R7 half not 4");
  endtask

  task automatic t_psz16();
    cfg(2'd2, 2'd3, 4'd2, 4'd1);  // dsz 3 = 4 bytes, 64-byte page
    do_access(32'h1C, 1'b0, 1'b0, "R3");
    do_access(32'h20, 1'b0, 1'b1, "R8 16-word page");
    do_access(32'h3C, 1'b0, 1'b0, "R5");
    do_access(32'h40, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_after_last();
    cfg(2'd0, 2'd2, 4'd3, 4'd1);
    do_access(32'h500, 1'b1, 1'b0, "R3");
    do_access(32'h504, 1'b1, 1'b0, "R10 history cleared");
  endtask

  task automatic t_zero_wait();
    cfg(2'd0, 2'd2, 4'd0, 4'd0);
    do_access(32'h600, 1'b0, 1'b0, "R3 zero wait");
    do_access(32'h604, 1'b1, 1'b1, "R4 zero wait");
  endtask

  task automatic t_disable_mid();
    cfg(2'd0, 2'd2, 4'd3, 4'd1);
    do_access(32'h700, 1'b0, 1'b0, "R3");
    en = 1'b0;
    @(negedge clk);
    chk(strobe == 1'b0, "R2 strobe closed by disable", strobe, 0);
    en = 1'b1;
    @(negedge clk);
    do_access(32'h704, 1'b1, 1'b0, "R2 history cleared");
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_seq_word();
    t_nonseq();
    t_cross();
    t_byte();
    t_half();
    t_psz16();
    t_after_last();
    t_zero_wait();
    t_disable_mid();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule